// File: doc/BRIEF.md
# LCD Raster Timing and Pixel Gate

This block produces the raster timing for a parallel LCD panel: a line sync, a frame sync and a data-enable. It also admits pixel data from a valid/ready stream onto the panel data bus, but only while the scan is inside the visible window. Every timing figure is fixed when the block is built: the leading blank, the visible span, the trailing porch, the sync width and the sync polarity, each set separately for the horizontal and the vertical axis. A line is blank, then visible pixels, then porch. A frame is blank lines, then visible lines, then porch lines.

One pixel position lasts `BEATS` clock cycles. `BEATS` is 1 when a pixel is carried in one word. It is 3 when the panel takes the colour components one after another over a narrower bus. In that case the block clock must run at three times the pixel rate, and `DW * BEATS` is the width of one pixel.

The stream rules for back-pressure are as follows. `s_ready` is high only on beats inside the visible window, and only while the block is not discarding the rest of a frame. The panel timing never waits for the source. If `s_valid` is low on a visible beat, that beat is shown as zero. A start-of-packet marker is expected on the first visible beat of each frame. If a marker is accepted anywhere else, a sticky error flag is raised, that beat is discarded, and `s_ready` stays low until the first visible beat of the next frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: The scan position moves one pixel every `BEATS` clocks. A line spans `HB+HA+HF` pixel positions and a frame spans `VB+VA+VF` lines.
- R2: `lcd_de` is high exactly on beats whose pixel index lies in [HB, HB+HA) and whose line index lies in [VB, VB+VA). Blank comes before the visible span and porch comes after it.
- R3: `lcd_hsync` is at its asserted level for pixel indices 0 to HS-1 of every line and at the other level for the rest of the line. The asserted level is high when `H_POL`=1 and low when `H_POL`=0.
- R4: `lcd_vsync` is at its asserted level for line indices 0 to VS-1 of every frame and at the other level for the rest of the frame. The asserted level is high when `V_POL`=1 and low when `V_POL`=0.
- R5: `s_ready` is high on a beat only if that beat is visible and the block is not discarding the frame.
- R6: A beat accepted with `s_valid` and `s_ready` both high, and not rejected under R8, appears on `lcd_data` one clock later, together with `lcd_de` high for the same position.
- R7: `lcd_data` is zero on every visible beat that accepts nothing and on every beat where `lcd_de` is low.
- R8: If a beat is accepted with `s_sop` high and it is not the first visible beat of the frame (pixel index HB, line index VB, beat 0), `err_flag` goes high one clock later and stays high until reset. That beat shows zero, and `s_ready` stays low until the next frame's first visible beat.
- R9: While `rst` is high, the next clock puts the scan at pixel 0, line 0, beat 0, drives both syncs to their idle levels, clears `lcd_de`, `lcd_data` and `err_flag`, and ends any discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `BEATS` times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Stream beat offered |
| s_sop | input | 1 | Stream beat begins a frame |
| s_data | input | DW | Stream beat payload |
| s_ready | output | 1 | Block takes the offered beat this clock |
| lcd_data | output | DW | Panel data bus |
| lcd_de | output | 1 | Panel data-enable |
| lcd_hsync | output | 1 | Line sync |
| lcd_vsync | output | 1 | Frame sync |
| err_flag | output | 1 | Sticky misplaced start-of-packet flag |

## Verification
`s_ready` depends only on the present scan position and the discard state, so it is due in the same clock as the position. The sync levels, `lcd_de`, `lcd_data` and `err_flag` all pass through one output register, so each is due one clock after the beat that caused it. The bench steps a model position once per clock. At each falling edge it compares `s_ready` against the present position. It compares the registered outputs against the expectation it stored for the previous position. The reset checks are taken at the falling edge after the first clock with `rst` high.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    RG_BLANK  = 2'd0,
    RG_ACTIVE = 2'd1,
    RG_FRONT  = 2'd2
  } region_e;

  // level of a sync line given whether the pulse is on and its polarity
  function automatic logic sync_level(input logic on, input logic pol);
    return on ? pol : ~pol;
  endfunction

endpackage

// File: rtl/lcd_beat_ctr.sv
module lcd_beat_ctr #(
  parameter int BEATS = 3
) (
  input  logic clk,
  input  logic rst,
  output logic beat_first,
  output logic beat_last
);
  generate
    if (BEATS == 1) begin : g_single
      assign beat_first = 1'b1;
      assign beat_last  = 1'b1;
    end else begin : g_multi
      localparam int BW = $clog2(BEATS);
      logic [BW-1:0] beat_q;
      always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else if (beat_q == BW'(BEATS - 1)) beat_q <= '0;
        else beat_q <= beat_q + 1'b1;
      end
      assign beat_first = (beat_q == '0);
      assign beat_last  = (beat_q == BW'(BEATS - 1));
    end
  endgenerate
endmodule

// File: rtl/lcd_span_ctr.sv
module lcd_span_ctr
  import lcd_sync_pkg::*;
#(
  parameter int BLANK  = 3,
  parameter int ACTIVE = 4,
  parameter int FRONT  = 2,
  parameter int SYNC   = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    step,
  output logic    wrap,
  output logic    at_first_active,
  output logic    in_sync,
  output region_e region
);
  localparam int TOTAL = BLANK + ACTIVE + FRONT;
  localparam int CW    = $clog2(TOTAL + 1);

  generate
    if (SYNC < 1 || SYNC > BLANK) begin : g_bad_sync
      $error("sync pulse must fit inside the blank interval");
    end
  endgenerate

  logic [CW-1:0] pos_q;

  assign wrap = (pos_q == CW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else if (step) pos_q <= wrap ? '0 : pos_q + 1'b1;
  end

  always_comb begin
    if (pos_q < CW'(BLANK)) region = RG_BLANK;
    else if (pos_q < CW'(BLANK + ACTIVE)) region = RG_ACTIVE;
    else region = RG_FRONT;
  end

  assign at_first_active = (pos_q == CW'(BLANK));
  assign in_sync         = (pos_q < CW'(SYNC));
endmodule

// File: rtl/lcd_pix_gate.sv
module lcd_pix_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          frame_first,
  input  logic          s_valid,
  input  logic          s_sop,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic [DW-1:0] data_next,
  output logic          err_flag
);
  logic drop_q, drop_now, take, misplaced;

  // a discard ends on the first visible beat of a new frame
  assign drop_now  = drop_q & ~frame_first;
  assign s_ready   = active & ~drop_now;
  assign take      = s_valid & s_ready;
  assign misplaced = take & s_sop & ~frame_first;
  assign data_next = (take & ~misplaced) ? s_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q   <= 1'b0;
      err_flag <= 1'b0;
    end else if (misplaced) begin
      drop_q   <= 1'b1;
      err_flag <= 1'b1;
    end else if (frame_first) begin
      drop_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int   DW    = 8,
  parameter int   BEATS = 3,
  parameter int   HA    = 4,
  parameter int   HB    = 3,
  parameter int   HF    = 2,
  parameter int   HS    = 2,
  parameter int   VA    = 3,
  parameter int   VB    = 2,
  parameter int   VF    = 1,
  parameter int   VS    = 1,
  parameter logic H_POL = 1'b0,
  parameter logic V_POL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic          s_sop,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic [DW-1:0] lcd_data,
  output logic          lcd_de,
  output logic          lcd_hsync,
  output logic          lcd_vsync,
  output logic          err_flag
);
  generate
    if (!(BEATS == 1 || BEATS == 3)) begin : g_bad_beats
      $error("BEATS must be 1 or 3");
    end
  endgenerate

  logic    beat_first, beat_last;
  logic    h_wrap, h_first, h_sync;
  logic    v_wrap, v_first, v_sync;
  region_e h_region, v_region;
  logic    active, frame_first;
  logic [DW-1:0] data_next;

  lcd_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk(clk), .rst(rst), .beat_first(beat_first), .beat_last(beat_last)
  );

  lcd_span_ctr #(.BLANK(HB), .ACTIVE(HA), .FRONT(HF), .SYNC(HS)) u_hspan (
    .clk(clk), .rst(rst), .step(beat_last), .wrap(h_wrap),
    .at_first_active(h_first), .in_sync(h_sync), .region(h_region)
  );

  lcd_span_ctr #(.BLANK(VB), .ACTIVE(VA), .FRONT(VF), .SYNC(VS)) u_vspan (
    .clk(clk), .rst(rst), .step(beat_last & h_wrap), .wrap(v_wrap),
    .at_first_active(v_first), .in_sync(v_sync), .region(v_region)
  );

  assign active      = (h_region == RG_ACTIVE) && (v_region == RG_ACTIVE);
  assign frame_first = active & h_first & v_first & beat_first;

  lcd_pix_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst(rst), .active(active), .frame_first(frame_first),
    .s_valid(s_valid), .s_sop(s_sop), .s_data(s_data),
    .s_ready(s_ready), .data_next(data_next), .err_flag(err_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_de    <= 1'b0;
      lcd_data  <= '0;
      lcd_hsync <= ~H_POL;
      lcd_vsync <= ~V_POL;
    end else begin
      lcd_de    <= active;
      lcd_data  <= data_next;
      lcd_hsync <= sync_level(h_sync, H_POL);
      lcd_vsync <= sync_level(v_sync, V_POL);
    end
  end
endmodule

module lcd_sync_gen_chk #(
  parameter int   DW    = 8,
  parameter logic H_POL = 1'b0,
  parameter logic V_POL = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_sop,
  input logic [DW-1:0] s_data,
  input logic          s_ready,
  input logic [DW-1:0] lcd_data,
  input logic          lcd_de,
  input logic          lcd_hsync,
  input logic          lcd_vsync,
  input logic          err_flag
);
  // R5
  ready_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> lcd_de);

  // R7
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lcd_de |-> (lcd_data == '0));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !s_sop) |=> (lcd_data == $past(s_data)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!lcd_de && !err_flag && lcd_data == '0 &&
             lcd_hsync == ~H_POL && lcd_vsync == ~V_POL));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.DW(DW), .H_POL(H_POL), .V_POL(V_POL)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_sop(s_sop), .s_data(s_data),
  .s_ready(s_ready), .lcd_data(lcd_data), .lcd_de(lcd_de),
  .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .err_flag(err_flag)
);

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;
  localparam int   DW = 8, B = 3;
  localparam int   HA = 4, HB = 3, HF = 2, HS = 2;
  localparam int   VA = 3, VB = 2, VF = 1, VS = 1;
  localparam logic HP = 1'b0, VP = 1'b1;
  localparam int   HT = HA + HB + HF, VT = VA + VB + VF;
  localparam int   FRAME = B * HT * VT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_sop = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, lcd_de, lcd_hsync, lcd_vsync, err_flag;
  logic [DW-1:0] lcd_data;

  always #5 clk = ~clk;

  lcd_sync_gen #(.DW(DW), .BEATS(B), .HA(HA), .HB(HB), .HF(HF), .HS(HS),
    .VA(VA), .VB(VB), .VF(VF), .VS(VS), .H_POL(HP), .V_POL(VP)) u_lcd_sync_gen (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_sop(s_sop), .s_data(s_data),
    .s_ready(s_ready), .lcd_data(lcd_data), .lcd_de(lcd_de),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .err_flag(err_flag));

  int total = 0, bad = 0;
  bit done = 0;
  bit m_drop, m_err;
  logic e_de, e_hs, e_vs, e_err;
  logic [DW-1:0] e_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit pos_active(input int n);
    int h = (n / B) % HT, v = (n / (B * HT)) % VT;
    return (h >= HB && h < HB + HA && v >= VB && v < VB + VA);
  endfunction

  function automatic bit pos_first(input int n);
    return pos_active(n) && ((n / B) % HT == HB) && ((n / (B * HT)) % VT == VB)
           && (n % B == 0);
  endfunction

  task automatic check_reset_state();
    chk(lcd_de == 1'b0, "R9", "de", lcd_de, 0);
    chk(lcd_data == '0, "R9", "data", lcd_data, 0);
    chk(lcd_hsync == ~HP, "R9", "hsync", lcd_hsync, ~HP);
    chk(lcd_vsync == ~VP, "R9", "vsync", lcd_vsync, ~VP);
    chk(err_flag == 1'b0, "R9", "err", err_flag, 0);
  endtask

  // called at a falling edge with rst just released; runs ncyc positions
  task automatic run(input int ncyc, input int bad_pos);
    m_drop = 0;
    m_err  = 0;
    for (int n = 0; n < ncyc; n++) begin
      bit act, first, rdy, hsk, misp;
      int h, v;
      if (n > 0) begin
        chk(lcd_de == e_de, "R2", "de", lcd_de, e_de);
        chk(lcd_hsync == e_hs, "R3", "hsync", lcd_hsync, e_hs);
        chk(lcd_vsync == e_vs, "R4", "vsync", lcd_vsync, e_vs);
        chk(lcd_data == e_data, e_de ? "R6" : "R7", "data", lcd_data, e_data);
        chk(err_flag == e_err, "R8", "err", err_flag, e_err);
      end
      h = (n / B) % HT;
      v = (n / (B * HT)) % VT;
      act   = pos_active(n);
      first = pos_first(n);
      rdy   = act && !(m_drop && !first);
      chk(s_ready == rdy, "R5", "ready", s_ready, rdy);
      // stimulus for this position
      s_valid = ($urandom_range(3) != 0);
      s_sop   = first;
      s_data  = DW'($urandom_range(255));
      if (first) s_valid = 1'b1;
      if (n == bad_pos) begin
        s_valid = 1'b1;
        s_sop   = 1'b1;
      end
      if (!act && $urandom_range(3) == 0) s_sop = 1'b1; // ignored outside window
      hsk  = s_valid && rdy;
      misp = hsk && s_sop && !first;
      e_data = (hsk && !misp) ? s_data : '0;
      if (misp) begin
        m_drop = 1;
        m_err  = 1;
      end else if (first) begin
        m_drop = 0;
      end
      e_de  = act;
      e_hs  = (h < HS) ? HP : ~HP;   // R1 line length via hsync period
      e_vs  = (v < VS) ? VP : ~VP;   // R1 frame length via vsync period
      e_err = m_err;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // frame 2: misplaced start marker on line VB+1, pixel HB+1, beat 1
    run(5 * FRAME, 2 * FRAME + (VB + 1) * B * HT + (HB + 1) * B + 1);
    // mid-run reset clears the sticky flag
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // error in the first frame, recovery in the second
    run(2 * FRAME + 2, (VB + 2) * B * HT + (HB + 3) * B + 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule